// File: doc/BRIEF.md
# Power-Up Bus Role Selector

After reset this controller decides whether the device should run as the I2C bus master and boot its coefficients from an external serial EEPROM, or stay a plain I2C slave. It first synchronises the asynchronous active-low reset. For one strap address only, it then waits a settling time and sends a single probe to the EEPROM write address. The acknowledge result of that probe fixes the bus role until the next reset.

The controller drives a byte-level command interface towards a separate bit-level I2C engine. The commands are start, one address byte and stop, and the engine answers each one with a done pulse and an acknowledge bit. Towards the rest of the chip it provides:
- drive enables for the clock and data pads;
- a master flag;
- a one-cycle download request for the coefficient loader;
- the serial-audio format selector;
- a status code.

When the probe is not issued, or is not acknowledged, the device keeps its default values.

States and transitions:
- WAIT goes to START when the settle timer expires and the strap matches. It goes to SLAVE on its first active cycle when the strap does not match.
- START goes to ADDR when the engine reports done.
- ADDR goes to STOP on done, and records the acknowledge bit.
- STOP goes to LOAD on done if the acknowledge was seen, and to SLAVE if it was not.
- LOAD goes to MIDLE (master idle) when the loader reports completion.
- MIDLE and SLAVE are final until reset.

Top module: `boot_role_ctrl`

## Requirements
- R1: The internal reset is asserted at once by `rst_n` low and released only on the second rising clock edge after `rst_n` returns high. While in reset, `status` is 0 (WAIT), `is_master` is 0, `cmd_valid` is 0 and `fmt_sel` is 0.
- R2: While reset is active, `scl_oe` and `sda_oe` are 0. In the WAIT and SLAVE states they are also 0. They are 1 only in the START, ADDR, STOP, LOAD and MIDLE states.
- R3: With `strap_addr` equal to 7'h34, the block stays in status 0 for at least WAIT_US microseconds of clock cycles (CLK_HZ/1e6*WAIT_US cycles), and for at most 3 cycles longer. It then issues, in this order: op 0 (start), op 1 (byte) with `cmd_byte` = 8'hA0, and op 2 (stop). Status is 1 during the probe.
- R4: With any other strap value, including 7'h35, no command is ever issued. Status becomes 4 (SLAVE) within 3 cycles of reset release.
- R5: If the byte is acknowledged (`cmd_ack`=1 with `cmd_done`), then after the stop the status is 2 (LOAD), `is_master` is 1, and `dl_req` pulses exactly once for one cycle.
- R6: If the byte is not acknowledged, then after the stop the status is 4 (SLAVE), `is_master` is 0 and `dl_req` never pulses.
- R7: The stop command is issued whatever the acknowledge result.
- R8: `fmt_sel` is 2'b00 (I2S) in status 0, 1 and 2. In status 3 (MIDLE) and 4 (SLAVE) it follows `host_fmt`. The block moves from status 2 to 3 in the cycle after `dl_done` is seen.
- R9: Once in MIDLE or SLAVE, the role and status do not change until reset, whatever `dl_done`, `cmd_done` or `cmd_ack` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_addr | input | 7 | Strapped 7-bit device address |
| host_fmt | input | 2 | Audio format written by the host into the control register |
| dl_done | input | 1 | Coefficient download finished |
| cmd_done | input | 1 | Engine finished current command (one cycle) |
| cmd_ack | input | 1 | Acknowledge seen for the byte command, valid with cmd_done |
| cmd_valid | output | 1 | A command is requested |
| cmd_op | output | 2 | 0 start, 1 byte, 2 stop |
| cmd_byte | output | 8 | Byte to send for op 1 |
| scl_oe | output | 1 | Clock pad drive enable |
| sda_oe | output | 1 | Data pad drive enable |
| is_master | output | 1 | Device acts as bus master |
| dl_req | output | 1 | One-cycle download request |
| fmt_sel | output | 2 | Serial-audio format, 0 is I2S |
| status | output | 3 | 0 WAIT, 1 PROBE, 2 LOAD, 3 MIDLE, 4 SLAVE |

## Verification
The hardest situation to reach is the probe with its timing in full: a settle wait that runs out exactly, followed by three handshakes whose latency varies. The bench models the bit engine with a random latency of one to four cycles and a random acknowledge. It also reduces the wait to one microsecond, so many complete reset-to-role runs fit into one test. Directed runs cover the 7'h34 and 7'h35 straps with both acknowledge results. Random runs mix other strap values. After each final state is reached, the bench pulses the handshake inputs and the done input to show that the role no longer moves.

// File: rtl/boot_role_pkg.sv
package boot_role_pkg;
    typedef enum logic [2:0] {
        S_WAIT, S_START, S_ADDR, S_STOP, S_LOAD, S_MIDLE, S_SLAVE
    } state_t;

    localparam logic [1:0] OP_START = 2'd0;
    localparam logic [1:0] OP_BYTE  = 2'd1;
    localparam logic [1:0] OP_STOP  = 2'd2;

    localparam logic [2:0] STAT_WAIT  = 3'd0;
    localparam logic [2:0] STAT_PROBE = 3'd1;
    localparam logic [2:0] STAT_LOAD  = 3'd2;
    localparam logic [2:0] STAT_MIDLE = 3'd3;
    localparam logic [2:0] STAT_SLAVE = 3'd4;
endpackage

// File: rtl/boot_rst_sync.sv
module boot_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n_async,
    output logic rst_n_sync
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n_async) begin
        if (!rst_n_async) chain <= '0;
        else              chain <= {chain[STAGES-2:0], 1'b1};
    end

    assign rst_n_sync = chain[STAGES-1];

    // R1: the pad reset low always holds the internal reset
    always @(posedge clk) begin
        if (!rst_n_async)
            a_r1_reset_held: assert (!rst_n_sync);
    end
endmodule

// File: rtl/boot_wait_timer.sv
module boot_wait_timer #(
    parameter int CYCLES = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic expired
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt <= LOAD_VAL;
        else if (en && cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/boot_role_fsm.sv
module boot_role_fsm
    import boot_role_pkg::*;
#(
    parameter logic [7:0] EE_WADDR = 8'hA0,
    parameter int         FMT_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             probe_en,
    input  logic             timer_done,
    input  logic             cmd_done,
    input  logic             cmd_ack,
    input  logic             dl_done,
    input  logic [FMT_W-1:0] host_fmt,
    output logic             timer_en,
    output logic             cmd_valid,
    output logic [1:0]       cmd_op,
    output logic [7:0]       cmd_byte,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             is_master,
    output logic             dl_req,
    output logic [FMT_W-1:0] fmt_sel,
    output logic [2:0]       status
);
    localparam logic [FMT_W-1:0] FMT_I2S = '0;

    state_t state, state_nx;
    logic   ack_q, role_q, req_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            S_WAIT:  if (!probe_en)       state_nx = S_SLAVE;
                     else if (timer_done) state_nx = S_START;
            S_START: if (cmd_done) state_nx = S_ADDR;
            S_ADDR:  if (cmd_done) state_nx = S_STOP;
            S_STOP:  if (cmd_done) state_nx = ack_q ? S_LOAD : S_SLAVE;
            S_LOAD:  if (dl_done)  state_nx = S_MIDLE;
            S_MIDLE: state_nx = S_MIDLE;
            S_SLAVE: state_nx = S_SLAVE;
            default: state_nx = S_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_WAIT;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_q  <= 1'b0;
            role_q <= 1'b0;
            req_q  <= 1'b0;
        end else begin
            req_q <= 1'b0;
            if (state == S_ADDR && cmd_done) ack_q <= cmd_ack;
            if (state == S_STOP && cmd_done && ack_q) begin
                role_q <= 1'b1;
                req_q  <= 1'b1;
            end
        end
    end

    always_comb begin
        timer_en  = (state == S_WAIT);
        cmd_valid = 1'b0;
        cmd_op    = OP_START;
        cmd_byte  = EE_WADDR;
        scl_oe    = 1'b0;
        fmt_sel   = FMT_I2S;
        status    = STAT_WAIT;
        unique case (state)
            S_WAIT:  status = STAT_WAIT;
            S_START: begin cmd_valid = 1'b1; cmd_op = OP_START; scl_oe = 1'b1; status = STAT_PROBE; end
            S_ADDR:  begin cmd_valid = 1'b1; cmd_op = OP_BYTE;  scl_oe = 1'b1; status = STAT_PROBE; end
            S_STOP:  begin cmd_valid = 1'b1; cmd_op = OP_STOP;  scl_oe = 1'b1; status = STAT_PROBE; end
            S_LOAD:  begin scl_oe = 1'b1; status = STAT_LOAD; end
            S_MIDLE: begin scl_oe = 1'b1; fmt_sel = host_fmt; status = STAT_MIDLE; end
            S_SLAVE: begin fmt_sel = host_fmt; status = STAT_SLAVE; end
            default: status = STAT_WAIT;
        endcase
    end

    assign sda_oe    = scl_oe;
    assign is_master = role_q;
    assign dl_req    = req_q;

    // R2: pads released whenever internal reset is active
    always @(posedge clk) begin
        if (!rst_n)
            a_r2_pads_released: assert (!scl_oe && !sda_oe);
    end

    // R4: commands only ever appear for the probing strap
    a_r4_no_cmd_without_strap: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> probe_en);

    // R3: the byte sent is the EEPROM write address
    a_r3_probe_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_BYTE) |-> cmd_byte == EE_WADDR);

    // R5: the download request lasts one cycle and coincides with LOAD
    a_r5_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dl_req |=> !dl_req);
    a_r5_req_in_load: assert property (@(posedge clk) disable iff (!rst_n)
        dl_req |-> (status == STAT_LOAD && is_master));

    // R8: I2S held until the download has finished
    a_r8_i2s_early: assert property (@(posedge clk) disable iff (!rst_n)
        (status == STAT_WAIT || status == STAT_PROBE || status == STAT_LOAD) |-> fmt_sel == FMT_I2S);

    // R9: role is sticky
    a_r9_role_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        is_master |=> is_master);
    a_r9_slave_final: assert property (@(posedge clk) disable iff (!rst_n)
        (status == STAT_SLAVE) |=> (status == STAT_SLAVE && !is_master));
endmodule

// File: rtl/boot_role_ctrl.sv
module boot_role_ctrl
    import boot_role_pkg::*;
#(
    parameter int         CLK_HZ     = 50_000_000,
    parameter int         WAIT_US    = 400,
    parameter logic [6:0] PROBE_ADDR = 7'h34,
    parameter logic [7:0] EE_WADDR   = 8'hA0,
    parameter int         FMT_W      = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [6:0]       strap_addr,
    input  logic [FMT_W-1:0] host_fmt,
    input  logic             dl_done,
    input  logic             cmd_done,
    input  logic             cmd_ack,
    output logic             cmd_valid,
    output logic [1:0]       cmd_op,
    output logic [7:0]       cmd_byte,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             is_master,
    output logic             dl_req,
    output logic [FMT_W-1:0] fmt_sel,
    output logic [2:0]       status
);
    localparam int CYC_PER_US  = CLK_HZ / 1_000_000;
    localparam int WAIT_CYCLES = (CYC_PER_US * WAIT_US < 1) ? 1 : CYC_PER_US * WAIT_US;

    logic rst_i, timer_en, timer_done, probe_en;

    assign probe_en = (strap_addr == PROBE_ADDR);

    boot_rst_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n_async(rst_n), .rst_n_sync(rst_i)
    );

    boot_wait_timer #(.CYCLES(WAIT_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_i), .en(timer_en), .expired(timer_done)
    );

    boot_role_fsm #(.EE_WADDR(EE_WADDR), .FMT_W(FMT_W)) u_fsm (
        .clk(clk), .rst_n(rst_i), .probe_en(probe_en), .timer_done(timer_done),
        .cmd_done(cmd_done), .cmd_ack(cmd_ack), .dl_done(dl_done), .host_fmt(host_fmt),
        .timer_en(timer_en), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_byte(cmd_byte),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .is_master(is_master), .dl_req(dl_req),
        .fmt_sel(fmt_sel), .status(status)
    );
endmodule

// File: tb/boot_role_ctrl_tb.sv
module boot_role_ctrl_tb;
    localparam int W = 50;  // 1 us at 50 MHz

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] strap_addr = 7'h34;
    logic [1:0] host_fmt = 2'd0;
    logic       dl_done = 1'b0;
    logic       cmd_done = 1'b0;
    logic       cmd_ack = 1'b0;
    logic       cmd_valid, scl_oe, sda_oe, is_master, dl_req;
    logic [1:0] cmd_op, fmt_sel;
    logic [7:0] cmd_byte;
    logic [2:0] status;

    int n_chk = 0, n_fail = 0;
    int eng_lat = 1, eng_cnt = 0;
    logic eng_ack = 1'b0;
    logic [1:0] op_log [0:7];
    int n_ops = 0, n_req = 0;
    logic byte_ok = 1'b1;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    boot_role_ctrl #(.CLK_HZ(50_000_000), .WAIT_US(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr), .host_fmt(host_fmt),
        .dl_done(dl_done), .cmd_done(cmd_done), .cmd_ack(cmd_ack),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_byte(cmd_byte),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .is_master(is_master), .dl_req(dl_req),
        .fmt_sel(fmt_sel), .status(status)
    );

    // bit-engine model and observers, all at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            cmd_done = 1'b0;
            if (dl_req) n_req++;
            if (cmd_valid) begin
                eng_cnt++;
                if (eng_cnt >= eng_lat) begin
                    eng_cnt = 0;
                    cmd_done = 1'b1;
                    cmd_ack = eng_ack;
                    if (n_ops < 8) op_log[n_ops] = cmd_op;
                    n_ops++;
                    if (cmd_op == 2'd1 && cmd_byte != 8'hA0) byte_ok = 1'b0;
                end
            end else eng_cnt = 0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit strap_probes(input logic [6:0] s);
        return s == 7'h34;
    endfunction

    task automatic run_case(input logic [6:0] s, input bit ack, input int lat, input logic [1:0] fmt);
        int waitc;
        int guard;
        @(negedge clk);
        rst_n = 1'b0;
        strap_addr = s; host_fmt = fmt; eng_lat = lat; eng_ack = ack;
        repeat (3) @(negedge clk);
        n_ops = 0; n_req = 0; byte_ok = 1'b1;
        chk("R1 status in reset", status, 0);
        chk("R1 is_master in reset", is_master, 0);
        chk("R1 cmd_valid in reset", cmd_valid, 0);
        chk("R1 fmt_sel in reset", fmt_sel, 0);
        chk("R2 scl_oe in reset", scl_oe, 0);
        chk("R2 sda_oe in reset", sda_oe, 0);
        rst_n = 1'b1;
        waitc = 0;
        @(negedge clk);
        while (status == 3'd0 && waitc < W + 20) begin
            waitc++;
            @(negedge clk);
        end
        if (strap_probes(s)) begin
            chk("R3 wait long enough", int'(waitc >= W), 1);
            chk("R3 wait not too long", int'(waitc <= W + 3), 1);
            chk("R3 probe status", status, 1);
            chk("R2 oe during probe", int'(scl_oe && sda_oe), 1);
            guard = 0;
            while (status == 3'd1 && guard < 100) begin guard++; @(negedge clk); end
            chk("R3 op count", n_ops, 3);
            chk("R3 op0 start", op_log[0], 0);
            chk("R3 op1 byte", op_log[1], 1);
            chk("R7 op2 stop", op_log[2], 2);
            chk("R3 byte A0", byte_ok, 1);
            if (ack) begin
                chk("R5 status load", status, 2);
                chk("R5 is_master", is_master, 1);
                chk("R8 fmt i2s in load", fmt_sel, 0);
                repeat (3) @(negedge clk);
                chk("R5 one dl_req pulse", n_req, 1);
                chk("R8 still i2s before done", fmt_sel, 0);
                dl_done = 1'b1;
                @(negedge clk);
                dl_done = 1'b0;
                chk("R8 midle status", status, 3);
                chk("R8 host format applied", fmt_sel, fmt);
                chk("R2 oe in midle", scl_oe, 1);
            end else begin
                chk("R6 status slave", status, 4);
                chk("R6 not master", is_master, 0);
                repeat (3) @(negedge clk);
                chk("R6 no dl_req", n_req, 0);
                chk("R2 oe in slave", int'(scl_oe || sda_oe), 0);
                chk("R8 host format in slave", fmt_sel, fmt);
            end
        end else begin
            chk("R4 fast slave", int'(waitc <= 3), 1);
            chk("R4 status slave", status, 4);
            repeat (W + 10) @(negedge clk);
            chk("R4 no commands", n_ops, 0);
            chk("R4 not master", is_master, 0);
        end
        // R9: disturb inputs after the final state
        begin
            logic [2:0] st0;
            logic       m0;
            st0 = status; m0 = is_master;
            dl_done = 1'b1; eng_ack = ~ack;
            repeat (4) @(negedge clk);
            dl_done = 1'b0;
            @(negedge clk);
            chk("R9 status fixed", status, st0);
            chk("R9 role fixed", is_master, m0);
            chk("R9 no extra dl_req", n_req, (strap_probes(s) && ack) ? 1 : 0);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        run_case(7'h34, 1'b1, 1, 2'd2);
        run_case(7'h34, 1'b0, 3, 2'd1);
        run_case(7'h35, 1'b1, 2, 2'd3);
        run_case(7'h34, 1'b1, 4, 2'd3);
        for (int i = 0; i < 10; i++) begin
            logic [6:0] s;
            s = ($urandom % 3 == 0) ? 7'($urandom % 128) : 7'h34;
            run_case(s, 1'($urandom % 2), 1 + int'($urandom % 4), 2'($urandom % 4));
        end
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule